// File: doc/BRIEF.md
# Link Alarm Control Word Handler

This block owns the single control byte that a CPRI-style serial link carries once per hyperframe for reset, service-disruption (SDI) and alarm signalling. On the transmit side it merges pin requests and configuration-register requests into that byte. It also marks local loss of signal (LOS) and loss of frame (LOF), and it sends the remote alarm indication (RAI) whenever either local loss is present. On the receive side it takes the inbound byte at the control-word position of each hyperframe while frame sync is held. It presents the partner's reset, SDI and alarm bits as registered levels, and it counts received hyperframes.

A run-time role input selects how the single reset bit is read. In the master role the outbound bit is a reset request and the inbound bit is an acknowledge. In the slave role the request pin is also accepted as an acknowledge source, and the received bit is additionally presented as a request output. All inputs are levels or single-cycle strobes in one clock domain. Every output is registered, with a latency of one clock.

Top module: `link_alarm_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every output to 0 on the next clock, including the transmit byte and the hyperframe number.
- R2: The transmit byte has this layout: bit 0 is reset, bit 1 is RAI, bit 2 is SDI, bit 3 is LOS and bit 4 is LOF. Bits 7:5 are always 0. One clock after its inputs, bit 2 equals the SDI pin ORed with the SDI configuration bit.
- R3: One clock after its inputs, transmit bit 0 equals the reset-request pin OR the reset configuration bit. When the role input is Low, the reset-acknowledge pin is also ORed in.
- R4: The local LOS and local LOF outputs follow their loss inputs with a latency of one clock. The local RAI output is their OR.
- R5: Transmit bit 3 carries local LOS, bit 4 carries local LOF, and bit 1 carries their OR. All three appear one clock after the inputs.
- R6: When the byte-valid strobe is High while sync is High, the received SDI (bit 2), LOS (bit 3), LOF (bit 4) and RAI (bit 1) appear on their outputs one clock later. They hold their values while no valid byte arrives.
- R7: While sync is Low, every received-status output and the hyperframe number clear to 0 on the next clock. The byte-valid strobe is then ignored.
- R8: The reset-acknowledge output holds received bit 0. The reset-request output holds received bit 0 gated by a Low role input. Both update one clock after a change of the captured bit or of the role.
- R9: The hyperframe number advances by one on each accepted byte and wraps from 149 to 0.
- R10: Bits 7:5 of a received byte have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| rst_req_pin | input | 1 | Reset-request input (also an acknowledge source in the slave role) |
| rst_ack_pin | input | 1 | Reset-acknowledge input, used in the slave role |
| sdi_pin | input | 1 | SDI request input |
| cfg_rst | input | 1 | Reset bit from the configuration register |
| cfg_sdi | input | 1 | SDI bit from the configuration register |
| los_in | input | 1 | Local loss-of-signal detection |
| lof_in | input | 1 | Local loss-of-frame detection |
| rx_byte | input | 8 | Inbound control byte |
| rx_vld | input | 1 | Strobe marking the control-word position of a hyperframe |
| rx_sync | input | 1 | Frame synchronisation held |
| tx_byte | output | 8 | Outbound control byte |
| local_los | output | 1 | Registered local LOS |
| local_lof | output | 1 | Registered local LOF |
| local_rai | output | 1 | Local RAI (LOS or LOF) |
| rst_ack_out | output | 1 | Received reset bit |
| rst_req_out | output | 1 | Received reset bit, valid as a request in the slave role |
| sdi_out | output | 1 | Received SDI bit |
| rem_los | output | 1 | Received LOS bit |
| rem_lof | output | 1 | Received LOF bit |
| rem_rai | output | 1 | Received RAI bit |
| hf_num | output | 8 | Received hyperframe number, 0 to 149 |

## Verification
A wrong captured alarm field shows at a remote-status or reset output one clock after the strobe. Without any further stimulus it stays wrong until the next accepted byte or the next loss of sync. A counter that is off by one, or that wraps at the wrong value, shows on the hyperframe number within a single accepted byte, and at the latest at the 150th byte. The transmit byte has no state beyond its output register, so an error in the merge or role logic appears on the very next clock. The bench therefore compares every output against its model on every clock.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // Bit order of the alarm fields inside the control byte; the far end decodes it.
  typedef struct packed {
    logic lof;  // bit 4
    logic los;  // bit 3
    logic sdi;  // bit 2
    logic rai;  // bit 1
    logic rst;  // bit 0
  } alarm_t;

  localparam int ALARM_W = $bits(alarm_t);

  function automatic alarm_t alarm_from_byte(input logic [ALARM_W-1:0] low_bits);
    return alarm_t'(low_bits);
  endfunction
endpackage

// File: rtl/lac_tx_builder.sv
module lac_tx_builder
  import lac_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_master,
  input  logic              rst_req_pin,
  input  logic              rst_ack_pin,
  input  logic              sdi_pin,
  input  logic              cfg_rst,
  input  logic              cfg_sdi,
  input  logic              los_in,
  input  logic              lof_in,
  output logic [CTRL_W-1:0] tx_byte,
  output logic              local_los,
  output logic              local_lof,
  output logic              local_rai
);
  localparam int PAD_W = CTRL_W - ALARM_W;

  alarm_t nxt;

  always_comb begin
    nxt     = '0;
    // Pin and register sources are ORed; in the slave role the ack pin joins in.
    nxt.rst = rst_req_pin | cfg_rst | (~role_master & rst_ack_pin);
    nxt.sdi = sdi_pin | cfg_sdi;
    nxt.los = los_in;
    nxt.lof = lof_in;
    nxt.rai = los_in | lof_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte   <= '0;
      local_los <= 1'b0;
      local_lof <= 1'b0;
      local_rai <= 1'b0;
    end else begin
      tx_byte   <= {{PAD_W{1'b0}}, nxt};
      local_los <= los_in;
      local_lof <= lof_in;
      local_rai <= los_in | lof_in;
    end
  end

  // R2
  sdi_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_byte[2] == $past(sdi_pin | cfg_sdi));
  // R5
  tx_rai_chk: assert property (@(posedge clk) disable iff (rst)
    tx_byte[1] == (tx_byte[3] | tx_byte[4]));
  // R4
  local_rai_chk: assert property (@(posedge clk) disable iff (rst)
    local_rai == (local_los | local_lof));
  // R3
  tx_master_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (role_master && !rst_req_pin && !cfg_rst) |=> !tx_byte[0]);
endmodule

// File: rtl/lac_rx_parser.sv
module lac_rx_parser
  import lac_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_master,
  input  logic [CTRL_W-1:0] rx_byte,
  input  logic              rx_vld,
  input  logic              rx_sync,
  output logic              rst_ack_out,
  output logic              rst_req_out,
  output logic              sdi_out,
  output logic              rem_los,
  output logic              rem_lof,
  output logic              rem_rai
);
  alarm_t held, nxt;

  always_comb begin
    if (!rx_sync)    nxt = '0;
    else if (rx_vld) nxt = alarm_from_byte(rx_byte[ALARM_W-1:0]);
    else             nxt = held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held        <= '0;
      rst_ack_out <= 1'b0;
      rst_req_out <= 1'b0;
    end else begin
      held        <= nxt;
      rst_ack_out <= nxt.rst;
      rst_req_out <= nxt.rst & ~role_master;
    end
  end

  assign sdi_out = held.sdi;
  assign rem_los = held.los;
  assign rem_lof = held.lof;
  assign rem_rai = held.rai;

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_sync |=> !(sdi_out | rem_los | rem_lof | rem_rai | rst_ack_out | rst_req_out));
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_sync && !rx_vld) |=> $stable({sdi_out, rem_los, rem_lof, rem_rai}));
  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_out |-> rst_ack_out);
endmodule

// File: rtl/lac_hf_counter.sv
module lac_hf_counter #(
  parameter int HF_CNT = 150,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] hf_num
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HF_CNT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)   hf_num <= '0;
    else if (adv)     hf_num <= (hf_num == LAST) ? '0 : hf_num + 1'b1;
  end

  // R9
  hf_range_chk: assert property (@(posedge clk) disable iff (rst)
    hf_num <= LAST);
  // R9
  hf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && hf_num == LAST) |=> hf_num == '0);
endmodule

// File: rtl/link_alarm_ctrl.sv
module link_alarm_ctrl
  import lac_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int HF_CNT = 150,
  parameter int HF_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_master,
  input  logic              rst_req_pin,
  input  logic              rst_ack_pin,
  input  logic              sdi_pin,
  input  logic              cfg_rst,
  input  logic              cfg_sdi,
  input  logic              los_in,
  input  logic              lof_in,
  input  logic [CTRL_W-1:0] rx_byte,
  input  logic              rx_vld,
  input  logic              rx_sync,
  output logic [CTRL_W-1:0] tx_byte,
  output logic              local_los,
  output logic              local_lof,
  output logic              local_rai,
  output logic              rst_ack_out,
  output logic              rst_req_out,
  output logic              sdi_out,
  output logic              rem_los,
  output logic              rem_lof,
  output logic              rem_rai,
  output logic [HF_W-1:0]   hf_num
);
  logic accept;
  assign accept = rx_vld & rx_sync;

  lac_tx_builder #(.CTRL_W(CTRL_W)) u_tx (
    .clk(clk), .rst(rst), .role_master(role_master),
    .rst_req_pin(rst_req_pin), .rst_ack_pin(rst_ack_pin), .sdi_pin(sdi_pin),
    .cfg_rst(cfg_rst), .cfg_sdi(cfg_sdi), .los_in(los_in), .lof_in(lof_in),
    .tx_byte(tx_byte), .local_los(local_los), .local_lof(local_lof),
    .local_rai(local_rai)
  );

  lac_rx_parser #(.CTRL_W(CTRL_W)) u_rx (
    .clk(clk), .rst(rst), .role_master(role_master),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .rx_sync(rx_sync),
    .rst_ack_out(rst_ack_out), .rst_req_out(rst_req_out), .sdi_out(sdi_out),
    .rem_los(rem_los), .rem_lof(rem_lof), .rem_rai(rem_rai)
  );

  lac_hf_counter #(.HF_CNT(HF_CNT), .CNT_W(HF_W)) u_hf (
    .clk(clk), .rst(rst), .clr(~rx_sync), .adv(accept), .hf_num(hf_num)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (tx_byte == '0 && hf_num == '0 && !local_rai && !rst_ack_out && !rem_rai));
  // R9
  hf_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_sync && !rx_vld) |=> $stable(hf_num));
endmodule

// File: tb/tb_link_alarm_ctrl.sv
module tb_link_alarm_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role_master = 1'b1, rst_req_pin = 0, rst_ack_pin = 0, sdi_pin = 0;
  logic cfg_rst = 0, cfg_sdi = 0, los_in = 0, lof_in = 0;
  logic [7:0] rx_byte = '0;
  logic rx_vld = 0, rx_sync = 0;
  logic [7:0] tx_byte, hf_num;
  logic local_los, local_lof, local_rai, rst_ack_out, rst_req_out;
  logic sdi_out, rem_los, rem_lof, rem_rai;

  always #5 clk = ~clk;

  link_alarm_ctrl dut (
    .clk(clk), .rst(rst), .role_master(role_master), .rst_req_pin(rst_req_pin),
    .rst_ack_pin(rst_ack_pin), .sdi_pin(sdi_pin), .cfg_rst(cfg_rst), .cfg_sdi(cfg_sdi),
    .los_in(los_in), .lof_in(lof_in), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .rx_sync(rx_sync), .tx_byte(tx_byte), .local_los(local_los),
    .local_lof(local_lof), .local_rai(local_rai), .rst_ack_out(rst_ack_out),
    .rst_req_out(rst_req_out), .sdi_out(sdi_out), .rem_los(rem_los),
    .rem_lof(rem_lof), .rem_rai(rem_rai), .hf_num(hf_num)
  );

  int compared = 0, mismatched = 0;
  bit started = 0;
  // behavioural model state
  int m_tx = 0, m_llos = 0, m_llof = 0, m_lrai = 0, m_rx = 0, m_hf = 0, m_ack = 0, m_req = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_tx = 0; m_llos = 0; m_llof = 0; m_lrai = 0; m_rx = 0; m_hf = 0; m_ack = 0; m_req = 0;
    end else begin
      m_tx = 0;
      if (rst_req_pin || cfg_rst || (!role_master && rst_ack_pin)) m_tx += 1;
      if (los_in || lof_in) m_tx += 2;
      if (sdi_pin || cfg_sdi) m_tx += 4;
      if (los_in) m_tx += 8;
      if (lof_in) m_tx += 16;
      m_llos = los_in; m_llof = lof_in; m_lrai = los_in | lof_in;
      if (!rx_sync) begin
        m_rx = 0; m_hf = 0;
      end else if (rx_vld) begin
        m_rx = rx_byte % 32;
        m_hf = (m_hf + 1) % 150;
      end
      m_ack = m_rx % 2;
      m_req = (m_rx % 2) & !role_master;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Compare everything away from the active edge, on every clock.
  always @(negedge clk) if (started) begin
    chk(rst ? "R1 tx" : "R3 tx reset bit", tx_byte[0], m_tx % 2);
    chk("R5 tx rai bit", tx_byte[1], (m_tx / 2) % 2);
    chk("R2 tx sdi bit", tx_byte[2], (m_tx / 4) % 2);
    chk("R5 tx los/lof bits", tx_byte[4:3], (m_tx / 8) % 4);
    chk("R2 tx high bits", tx_byte[7:5], 0);
    chk("R4 local los", local_los, m_llos);
    chk("R4 local lof", local_lof, m_llof);
    chk("R4 local rai", local_rai, m_lrai);
    chk("R6 rx sdi", sdi_out, (m_rx / 4) % 2);
    chk("R6 rx rai", rem_rai, (m_rx / 2) % 2);
    chk("R6 rx los", rem_los, (m_rx / 8) % 2);
    chk("R6 rx lof", rem_lof, (m_rx / 16) % 2);
    chk("R8 ack out", rst_ack_out, m_ack);
    chk("R8 req out", rst_req_out, m_req);
    chk("R9 hf num", hf_num, m_hf);
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_vld = 1; step(1);
    rx_vld = 0; step(2);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    // R1: reset state directly
    chk("R1 reset tx", tx_byte, 0);
    chk("R1 reset hf", hf_num, 0);
    rst = 0;
    // R2 R3 R4 R5: every combination of transmit-side inputs
    for (int i = 0; i < 256; i++) begin
      {role_master, rst_req_pin, rst_ack_pin, sdi_pin, cfg_rst, cfg_sdi, los_in, lof_in} = 8'(i);
      step(1);
    end
    role_master = 1; {rst_req_pin, rst_ack_pin, sdi_pin, cfg_rst, cfg_sdi, los_in, lof_in} = '0;
    // R6 R8 R9: stream bytes under sync with role changes, past the wrap
    rx_sync = 1; step(1);
    for (int i = 0; i < 160; i++) begin
      if (i % 40 == 20) role_master = ~role_master;
      send(8'((i * 37 + 11) % 256));
    end
    // R10: high bits alone change nothing
    send(8'hE0);
    chk("R10 high bits only", {rem_los, rem_lof, rem_rai, sdi_out, rst_ack_out}, 0);
    send(8'hFF);
    send(8'h1F);
    chk("R10 same low bits", {rem_los, rem_lof, rem_rai, sdi_out, rst_ack_out}, 5'h1F);
    // R7: sync loss clears and strobes are ignored
    rx_sync = 0; step(1);
    chk("R7 cleared", {rem_los, rem_lof, rem_rai, sdi_out, rst_ack_out, rst_req_out}, 0);
    chk("R7 hf cleared", hf_num, 0);
    send(8'h1F);
    chk("R7 strobe ignored", {rem_los, sdi_out, hf_num}, 0);
    // R8: role toggle with a held reset bit
    rx_sync = 1; role_master = 1; send(8'h01);
    chk("R8 master req low", rst_req_out, 0);
    role_master = 0; step(1);
    chk("R8 slave req high", rst_req_out, 1);
    // R1: reset in the middle of traffic
    los_in = 1; send(8'h1B); rst = 1; step(2);
    chk("R1 mid reset", {tx_byte, hf_num, rem_lof, local_rai}, 0);
    rst = 0; step(4);
    summary();
  end
endmodule